// File: doc/BRIEF.md
# Memory Controller Request Adapter

This block sits between a local client and the internal request port of an embedded DDR3 memory controller. The client hands it read and write commands, each carrying a row, a bank, a column and a burst length. The adapter packs these fields into the controller's flat address and issues the request only when the controller's aligned busy flag allows it. Read data returned by the controller is passed back to the client.

Write data is pulled by the controller rather than pushed by the client. The client first loads data words into a small write buffer. A write command is taken only once its whole burst is already held in that buffer and not promised to an earlier command. The controller raises an early warning some cycles before each one-cycle data strobe. On that warning the adapter reads the next word out of its buffer into a short prefetch queue. The word is then presented on the cycle that follows the strobe.

On the read side, a running count of expected beats is kept. Beats flagged valid are forwarded one cycle later. A valid beat that arrives when no read beat is outstanding is not forwarded and raises an error pulse instead.

Top module: `mc_req_adapter`

## Requirements
- R1: After reset, mc_wr_req, mc_rd_req, cl_rdata_valid and cl_rd_err are low, mc_wdata is zero, and cl_wdata_ready is high because the write buffer is empty.
- R2: An accepted command appears on mc_wr_req (write) or mc_rd_req (read) for exactly one cycle, in the cycle after acceptance. mc_addr equals {row, bank, col}, with the column in the least significant COL_W bits, the bank directly above it and the row on top. mc_burst carries the burst value unchanged. Requests leave in acceptance order, and at most one is high in any cycle.
- R3: cl_cmd_ready is low for a command whose burst is zero, is not a multiple of 4, or exceeds WBUF_DEPTH. It is also low when the column's two low bits are not zero.
- R4: cl_cmd_ready is low in any cycle where mc_busy is high. A request output is high only in a cycle whose preceding cycle had mc_busy low.
- R5: A write command is ready only when the write buffer holds at least burst words not already claimed by earlier accepted writes. A read command needs no buffered data.
- R6: For every mc_wdata_req strobe, mc_wdata in the following cycle carries the next buffered word, in the order the client pushed them. This holds across successive commands.
- R7: Each mc_wdata_req_early pulse fetches one buffered word ahead of its strobe. Any lead from 1 to PF_DEPTH cycles between an early pulse and its strobe delivers correct data.
- R8: Write commands presented on consecutive cycles are accepted on consecutive cycles while mc_busy stays low and the buffer holds their data.
- R9: A beat with mc_rdata_valid high, arriving while read beats are outstanding, appears on cl_rdata with cl_rdata_valid high one cycle later, with the data unchanged. Beats are delivered in arrival order.
- R10: A beat with mc_rdata_valid high that arrives when no read beat is outstanding is not forwarded. It raises cl_rd_err for one cycle, one cycle later.
- R11: cl_wdata_ready stays high while fewer than WBUF_DEPTH words are held that have not yet been fetched. Once the buffer is full it drops, and no further word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cl_cmd_valid | input | 1 | Client command present |
| cl_cmd_write | input | 1 | 1 = write command, 0 = read command |
| cl_cmd_row | input | ROW_W | Row field |
| cl_cmd_bank | input | BANK_W | Bank field |
| cl_cmd_col | input | COL_W | Column field, two low bits must be zero |
| cl_cmd_burst | input | 8 | Burst length in data words |
| cl_cmd_ready | output | 1 | Command taken in this cycle if valid |
| cl_wdata_valid | input | 1 | Client write word present |
| cl_wdata | input | DATA_W | Client write word |
| cl_wdata_ready | output | 1 | Write buffer can take a word |
| cl_rdata_valid | output | 1 | Returned read word valid |
| cl_rdata | output | DATA_W | Returned read word |
| cl_rd_err | output | 1 | Read beat arrived with nothing outstanding |
| mc_busy | input | 1 | Controller busy, aligned to clk |
| mc_wr_req | output | 1 | Write request to controller |
| mc_rd_req | output | 1 | Read request to controller |
| mc_addr | output | ROW_W+BANK_W+COL_W | Flat request address |
| mc_burst | output | 8 | Request burst size |
| mc_wdata_req_early | input | 1 | Early warning of a coming data strobe |
| mc_wdata_req | input | 1 | Data strobe, word due next cycle |
| mc_wdata | output | DATA_W | Write word to controller |
| mc_rdata_valid | input | 1 | Controller read beat valid |
| mc_rdata | input | DATA_W | Controller read beat |

## Verification
The bench repeats the same mix of write bursts of 4, 8, 12 and 16 words, followed by reads, under every combination of three early-to-strobe leads and three busy patterns. Each early warning comes either every cycle or every other cycle. Varying the lead exposes any mismatch between the prefetch queue and the strobe timing. Varying the busy pattern separates correct gating from requests that slip through, and sustained strobes against spaced ones expose the bypass path for words not yet queued. Directed probes hold a write whose burst exceeds the buffered data, fill the buffer to its limit, offer illegal burst and column values, issue back-to-back commands, and inject a read beat that no read asked for.

// File: rtl/mcra_pkg.sv
package mcra_pkg;
  localparam int BURST_W = 8;

  // burst must be a nonzero multiple of 4 that the write buffer can hold
  function automatic logic burst_legal(input logic [BURST_W-1:0] b,
                                       input int unsigned max_len);
    return (b != '0) && (b[1:0] == 2'b00) && (32'(b) <= max_len);
  endfunction
endpackage

// File: rtl/mcra_wbuf.sv
module mcra_wbuf #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int PF_DEPTH = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  input  logic              claim,
  input  logic [7:0]        claim_len,
  output logic [CW-1:0]     unclaimed,
  input  logic              early,
  input  logic              req,
  output logic [DATA_W-1:0] wdata
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = $clog2(PF_DEPTH);
  localparam int PCW = $clog2(PF_DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, pp;
  logic [CW-1:0]     fill, resv;
  logic [DATA_W-1:0] rd_data;
  logic              rd_vld;
  logic [DATA_W-1:0] sk_q [PF_DEPTH];
  logic [PW-1:0]     sk_wp, sk_rp;
  logic [PCW-1:0]    sk_cnt;
  logic              push, take_skid, bypass, sk_push;

  assign push_ready = fill < CW'(DEPTH);
  assign push       = push_valid && push_ready;
  assign unclaimed  = fill - resv;
  assign take_skid  = req && (sk_cnt != '0);
  assign bypass     = req && (sk_cnt == '0);
  assign sk_push    = rd_vld && !bypass;

  // storage without reset so it maps to block RAM, registered read
  always_ff @(posedge clk) begin
    if (push)  mem[wp] <= push_data;
    if (early) rd_data <= mem[pp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      pp     <= '0;
      fill   <= '0;
      resv   <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (push)  wp <= wp + AW'(1);
      if (early) pp <= pp + AW'(1);
      fill   <= fill + CW'(push) - CW'(early);
      resv   <= resv + (claim ? CW'(claim_len) : CW'(0)) - CW'(early);
      rd_vld <= early;
    end
  end

  always_ff @(posedge clk) begin
    if (sk_push) sk_q[sk_wp] <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_wp  <= '0;
      sk_rp  <= '0;
      sk_cnt <= '0;
      wdata  <= '0;
    end else begin
      if (sk_push)   sk_wp <= sk_wp + PW'(1);
      if (take_skid) sk_rp <= sk_rp + PW'(1);
      sk_cnt <= sk_cnt + PCW'(sk_push) - PCW'(take_skid);
      if (req) wdata <= take_skid ? sk_q[sk_rp] : rd_data;
    end
  end

  // R6
  no_skid_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> (sk_cnt != '0 || rd_vld));
  // R7
  skid_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sk_cnt <= PCW'(PF_DEPTH));
  // R5
  resv_le_fill_chk: assert property (@(posedge clk) disable iff (rst)
    resv <= fill);
  // R11
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
endmodule

// File: rtl/mcra_issue.sv
module mcra_issue
  import mcra_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int AD_W  = COL_W + BANK_W + ROW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic               cmd_write,
  input  logic [ROW_W-1:0]   cmd_row,
  input  logic [BANK_W-1:0]  cmd_bank,
  input  logic [COL_W-1:0]   cmd_col,
  input  logic [BURST_W-1:0] cmd_burst,
  output logic               cmd_ready,
  input  logic               busy,
  input  logic [CW-1:0]      unclaimed,
  output logic               claim,
  output logic               rd_accept,
  output logic [BURST_W-1:0] acc_len,
  output logic               mc_wr_req,
  output logic               mc_rd_req,
  output logic [AD_W-1:0]    mc_addr,
  output logic [BURST_W-1:0] mc_burst
);
  logic legal, fits, acc;

  assign legal     = burst_legal(cmd_burst, DEPTH) && (cmd_col[1:0] == 2'b00);
  assign fits      = !cmd_write || (16'(unclaimed) >= 16'(cmd_burst));
  assign cmd_ready = !busy && legal && fits;
  assign acc       = cmd_valid && cmd_ready;
  assign claim     = acc && cmd_write;
  assign rd_accept = acc && !cmd_write;
  assign acc_len   = cmd_burst;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_wr_req <= 1'b0;
      mc_rd_req <= 1'b0;
      mc_addr   <= '0;
      mc_burst  <= '0;
    end else begin
      mc_wr_req <= claim;
      mc_rd_req <= rd_accept;
      if (acc) begin
        mc_addr  <= {cmd_row, cmd_bank, cmd_col};
        mc_burst <= cmd_burst;
      end
    end
  end

  // R4
  req_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_wr_req || mc_rd_req) |-> !$past(busy));
  // R2
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mc_wr_req, mc_rd_req}));
endmodule

// File: rtl/mcra_rdret.sv
module mcra_rdret #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_accept,
  input  logic [7:0]        rd_len,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  logic [CNT_W-1:0] pending;
  logic             have, good;

  assign have = pending != '0;
  assign good = beat_valid && have;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      pending   <= pending + (rd_accept ? CNT_W'(rd_len) : CNT_W'(0)) - CNT_W'(good);
      out_valid <= good;
      out_err   <= beat_valid && !have;
      if (beat_valid) out_data <= beat_data;
    end
  end

  // R9
  fwd_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(beat_valid));
  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (!out_valid && $past(beat_valid)));
endmodule

// File: rtl/mc_req_adapter.sv
module mc_req_adapter #(
  parameter int COL_W      = 4,
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 4,
  parameter int DATA_W     = 16,
  parameter int WBUF_DEPTH = 16,
  parameter int PF_DEPTH   = 4,
  parameter int RD_CNT_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cl_cmd_valid,
  input  logic                          cl_cmd_write,
  input  logic [ROW_W-1:0]              cl_cmd_row,
  input  logic [BANK_W-1:0]             cl_cmd_bank,
  input  logic [COL_W-1:0]              cl_cmd_col,
  input  logic [7:0]                    cl_cmd_burst,
  output logic                          cl_cmd_ready,
  input  logic                          cl_wdata_valid,
  input  logic [DATA_W-1:0]             cl_wdata,
  output logic                          cl_wdata_ready,
  output logic                          cl_rdata_valid,
  output logic [DATA_W-1:0]             cl_rdata,
  output logic                          cl_rd_err,
  input  logic                          mc_busy,
  output logic                          mc_wr_req,
  output logic                          mc_rd_req,
  output logic [ROW_W+BANK_W+COL_W-1:0] mc_addr,
  output logic [7:0]                    mc_burst,
  input  logic                          mc_wdata_req_early,
  input  logic                          mc_wdata_req,
  output logic [DATA_W-1:0]             mc_wdata,
  input  logic                          mc_rdata_valid,
  input  logic [DATA_W-1:0]             mc_rdata
);
  localparam int CW = $clog2(WBUF_DEPTH + 1);

  logic [CW-1:0] unclaimed;
  logic          claim, rd_accept;
  logic [7:0]    acc_len;

  mcra_issue #(
    .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .DEPTH(WBUF_DEPTH)
  ) u_issue (
    .clk(clk), .rst(rst),
    .cmd_valid(cl_cmd_valid), .cmd_write(cl_cmd_write),
    .cmd_row(cl_cmd_row), .cmd_bank(cl_cmd_bank), .cmd_col(cl_cmd_col),
    .cmd_burst(cl_cmd_burst), .cmd_ready(cl_cmd_ready),
    .busy(mc_busy), .unclaimed(unclaimed),
    .claim(claim), .rd_accept(rd_accept), .acc_len(acc_len),
    .mc_wr_req(mc_wr_req), .mc_rd_req(mc_rd_req),
    .mc_addr(mc_addr), .mc_burst(mc_burst)
  );

  mcra_wbuf #(
    .DATA_W(DATA_W), .DEPTH(WBUF_DEPTH), .PF_DEPTH(PF_DEPTH)
  ) u_wbuf (
    .clk(clk), .rst(rst),
    .push_valid(cl_wdata_valid), .push_data(cl_wdata), .push_ready(cl_wdata_ready),
    .claim(claim), .claim_len(acc_len), .unclaimed(unclaimed),
    .early(mc_wdata_req_early), .req(mc_wdata_req), .wdata(mc_wdata)
  );

  mcra_rdret #(
    .DATA_W(DATA_W), .CNT_W(RD_CNT_W)
  ) u_rdret (
    .clk(clk), .rst(rst),
    .rd_accept(rd_accept), .rd_len(acc_len),
    .beat_valid(mc_rdata_valid), .beat_data(mc_rdata),
    .out_valid(cl_rdata_valid), .out_data(cl_rdata), .out_err(cl_rd_err)
  );
endmodule

// File: tb/tb_mc_req_adapter.sv
module tb_mc_req_adapter;
  localparam int COL_W = 4, BANK_W = 2, ROW_W = 4, DATA_W = 16, DEPTH = 16;
  localparam int RT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cl_cmd_valid = 0, cl_cmd_write = 0;
  logic [ROW_W-1:0] cl_cmd_row = '0;
  logic [BANK_W-1:0] cl_cmd_bank = '0;
  logic [COL_W-1:0] cl_cmd_col = '0;
  logic [7:0] cl_cmd_burst = '0;
  logic cl_cmd_ready;
  logic cl_wdata_valid = 0;
  logic [DATA_W-1:0] cl_wdata = '0;
  logic cl_wdata_ready, cl_rdata_valid, cl_rd_err;
  logic [DATA_W-1:0] cl_rdata;
  logic mc_busy = 0, mc_wr_req, mc_rd_req;
  logic [ROW_W+BANK_W+COL_W-1:0] mc_addr;
  logic [7:0] mc_burst;
  logic mc_wdata_req_early = 0, mc_wdata_req = 0;
  logic [DATA_W-1:0] mc_wdata;
  logic mc_rdata_valid = 0;
  logic [DATA_W-1:0] mc_rdata = '0;

  always #4 clk = ~clk;

  mc_req_adapter dut (
    .clk(clk), .rst(rst),
    .cl_cmd_valid(cl_cmd_valid), .cl_cmd_write(cl_cmd_write),
    .cl_cmd_row(cl_cmd_row), .cl_cmd_bank(cl_cmd_bank), .cl_cmd_col(cl_cmd_col),
    .cl_cmd_burst(cl_cmd_burst), .cl_cmd_ready(cl_cmd_ready),
    .cl_wdata_valid(cl_wdata_valid), .cl_wdata(cl_wdata), .cl_wdata_ready(cl_wdata_ready),
    .cl_rdata_valid(cl_rdata_valid), .cl_rdata(cl_rdata), .cl_rd_err(cl_rd_err),
    .mc_busy(mc_busy), .mc_wr_req(mc_wr_req), .mc_rd_req(mc_rd_req),
    .mc_addr(mc_addr), .mc_burst(mc_burst),
    .mc_wdata_req_early(mc_wdata_req_early), .mc_wdata_req(mc_wdata_req),
    .mc_wdata(mc_wdata), .mc_rdata_valid(mc_rdata_valid), .mc_rdata(mc_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int tcyc = 0;
  always @(posedge clk) tcyc <= tcyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wval(input int i);
    return (i * 37 + 5) & 16'hFFFF;
  endfunction
  function automatic int rval(input int a, input int b);
    return (a * 16 + b) & 16'hFFFF;
  endfunction

  // command log, written by the client at acceptance
  int lg_wr[256], lg_addr[256], lg_burst[256], lg_cyc[256];
  int lg_n = 0, is_n = 0, tot_w = 0;

  // controller model controls
  int lead = 1, busy_mode = 0, gap_mode = 0;
  bit stray_req = 0;
  int push_limit = 0, push_cnt = 0;

  // controller model state
  int cyc = 0, beats_pend = 0, wchk = 0;
  bit [7:0] dl = '0;
  bit prev_req = 0, prev_rv = 0, prev_stray = 0;
  int prev_rd = 0;
  int rq_val[1024], rq_due[1024];
  int rq_h = 0, rq_t = 0;

  // controller model: checks outputs, then drives the next inputs
  initial begin
    bit req_now, early_now;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (mc_wr_req || mc_rd_req) begin
          chk(!mc_busy, "R4 request after busy cycle", mc_busy, 0);
          if (is_n < lg_n) begin
            chk(mc_wr_req == lg_wr[is_n], "R2 request kind", mc_wr_req, lg_wr[is_n]);
            chk(int'(mc_addr) == lg_addr[is_n], "R2 address", int'(mc_addr), lg_addr[is_n]);
            chk(int'(mc_burst) == lg_burst[is_n], "R2 burst", int'(mc_burst), lg_burst[is_n]);
            if (mc_wr_req) beats_pend += int'(mc_burst);
            else begin
              for (int b = 0; b < int'(mc_burst); b++) begin
                rq_val[rq_t] = rval(int'(mc_addr), b);
                rq_due[rq_t] = cyc + RT;
                rq_t++;
              end
            end
            is_n++;
          end else chk(0, "R2 unexpected request", is_n, lg_n);
        end
        if (prev_req) begin
          chk(int'(mc_wdata) == wval(wchk), "R6 write word", int'(mc_wdata), wval(wchk));
          wchk++;
        end
        if (prev_rv || prev_stray || cl_rdata_valid || cl_rd_err) begin
          chk(cl_rdata_valid == prev_rv, "R9 read valid", cl_rdata_valid, prev_rv);
          if (prev_rv) chk(int'(cl_rdata) == prev_rd, "R9 read data", int'(cl_rdata), prev_rd);
          chk(cl_rd_err == prev_stray, "R10 stray error", cl_rd_err, prev_stray);
        end
      end
      case (busy_mode)
        1: mc_busy = (cyc % 3) == 1;
        2: mc_busy = (cyc % 8) < 3;
        3: mc_busy = 1'b1;
        default: mc_busy = 1'b0;
      endcase
      req_now = dl[lead-1];
      early_now = (beats_pend > 0) && (gap_mode == 0 || (cyc % 2) == 0);
      if (early_now) beats_pend--;
      dl = {dl[6:0], early_now};
      mc_wdata_req = req_now;
      mc_wdata_req_early = early_now;
      prev_req = req_now;
      prev_rv = 0;
      prev_stray = 0;
      if (rq_h < rq_t && rq_due[rq_h] <= cyc) begin
        mc_rdata_valid = 1'b1;
        mc_rdata = 16'(rq_val[rq_h]);
        prev_rv = 1;
        prev_rd = rq_val[rq_h];
        rq_h++;
      end else if (stray_req) begin
        mc_rdata_valid = 1'b1;
        mc_rdata = 16'hBEEF;
        prev_stray = 1;
        stray_req = 0;
      end else begin
        mc_rdata_valid = 1'b0;
        mc_rdata = 16'(cyc);
      end
      cyc++;
    end
  end

  // client data pusher
  initial begin
    forever begin
      @(negedge clk);
      cl_wdata_valid = !rst && (push_cnt < push_limit);
      cl_wdata = 16'(wval(push_cnt));
      #1;
      if (cl_wdata_valid && cl_wdata_ready) push_cnt++;
    end
  end

  task automatic set_cmd(input bit w, input int row, input int bank, input int col, input int burst);
    cl_cmd_write = w;
    cl_cmd_row = ROW_W'(row);
    cl_cmd_bank = BANK_W'(bank);
    cl_cmd_col = COL_W'(col);
    cl_cmd_burst = 8'(burst);
  endtask

  task automatic issue(input bit w, input int row, input int bank, input int col, input int burst);
    set_cmd(w, row, bank, col, burst);
    cl_cmd_valid = 1'b1;
    #1;
    while (!cl_cmd_ready) begin
      @(negedge clk);
      #1;
    end
    lg_wr[lg_n] = w;
    lg_addr[lg_n] = (row << (COL_W + BANK_W)) | (bank << COL_W) | col;
    lg_burst[lg_n] = burst;
    lg_cyc[lg_n] = tcyc;
    lg_n++;
    if (w) tot_w += burst;
    @(negedge clk);
    cl_cmd_valid = 1'b0;
  endtask

  task automatic probe(input bit w, input int row, input int bank, input int col, input int burst,
                       input bit exp, input string tag);
    cl_cmd_valid = 1'b0;
    set_cmd(w, row, bank, col, burst);
    #1;
    chk(cl_cmd_ready == exp, tag, cl_cmd_ready, exp);
    @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(!mc_wr_req && !mc_rd_req, "R1 requests low", mc_wr_req | mc_rd_req, 0);
    chk(!cl_rdata_valid && !cl_rd_err, "R1 read outputs low", cl_rdata_valid | cl_rd_err, 0);
    chk(mc_wdata == '0, "R1 write word zero", int'(mc_wdata), 0);
    chk(cl_wdata_ready, "R1 buffer empty", cl_wdata_ready, 1);
    @(negedge clk);

    // R5: only 4 words buffered
    push_limit = 4;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 3; i++) probe(1, 1, 1, 0, 8, 0, "R5 write 8 over 4 words");
    probe(1, 1, 1, 0, 4, 1, "R5 write 4 with 4 words");
    probe(0, 1, 1, 0, 8, 1, "R5 read needs no data");

    // R11: fill the buffer to its limit
    push_limit = 1000000;
    repeat (30) @(negedge clk);
    #1;
    chk(!cl_wdata_ready, "R11 ready low when full", cl_wdata_ready, 0);
    chk(push_cnt == DEPTH, "R11 words taken", push_cnt, DEPTH);
    @(negedge clk);

    // R3 illegal commands
    probe(1, 0, 0, 0, 6, 0, "R3 burst 6");
    probe(1, 0, 0, 0, 0, 0, "R3 burst 0");
    probe(0, 0, 0, 0, 20, 0, "R3 burst over depth");
    probe(0, 0, 0, 2, 4, 0, "R3 misaligned column");
    probe(0, 0, 0, 4, 16, 1, "R3 legal read");

    // R4 busy blocks acceptance
    busy_mode = 3;
    repeat (2) @(negedge clk);
    probe(0, 0, 0, 4, 4, 0, "R4 ready low while busy");
    probe(1, 0, 0, 4, 4, 0, "R4 write ready low while busy");
    busy_mode = 0;
    @(negedge clk);

    // R8 back-to-back writes from a full buffer
    issue(1, 3, 2, 8, 4);
    issue(1, 4, 1, 12, 4);
    issue(1, 5, 3, 0, 8);
    chk(lg_cyc[lg_n-2] == lg_cyc[lg_n-3] + 1, "R8 second accept", lg_cyc[lg_n-2], lg_cyc[lg_n-3] + 1);
    chk(lg_cyc[lg_n-1] == lg_cyc[lg_n-2] + 1, "R8 third accept", lg_cyc[lg_n-1], lg_cyc[lg_n-2] + 1);
    repeat (60) @(negedge clk);

    // R7 sweep over leads, busy patterns and strobe spacing
    for (int ld = 1; ld <= 3; ld++) begin
      for (int bm = 0; bm < 3; bm++) begin
        lead = ld;
        busy_mode = bm;
        gap_mode = (bm == 1) ? 1 : 0;
        for (int k = 0; k < 4; k++)
          issue(1, (k * 5 + ld * 3 + bm) % 16, k % 4, (k * 4) % 16, (k + 1) * 4);
        issue(0, (ld + bm) % 16, bm, 4, 4);
        issue(0, (ld * 7) % 16, 3 - bm, 8, 8);
        repeat (120) @(negedge clk);
        stray_req = 1;
        repeat (4) @(negedge clk);
      end
    end
    busy_mode = 0;
    repeat (40) @(negedge clk);
    chk(is_n == lg_n, "R2 all commands issued", is_n, lg_n);
    chk(wchk == tot_w, "R6 all words delivered", wchk, tot_w);
    chk(rq_h == rq_t, "R9 all read beats returned", rq_h, rq_t);
    summary();
    $finish;
  end
endmodule